// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. It holds two signed Q15 operand registers, X and Y. A 24-bit product register P follows them: any write to either operand forms a new product in the same clock edge, so no separate multiply command exists. The product is doubled to Q31 alignment and cut to its upper 24 bits. It can also be shifted right by three places with sign extension before it is stored, which gives headroom when many terms are summed.

A second path takes P through a four-setting operand shifter into a 24-bit ALU. The ALU writes a 24-bit accumulator and four flags: negative, overflow, zero and carry. Multiply-add and multiply-subtract use the P value present at the clock edge, so a new operand pair can be loaded in the same cycle as the accumulation of the previous product. A saturation control picks between clamping and wrapping. The accumulator can also be loaded with a 16-bit word, and its upper 16 bits are presented on a separate output. All strobes are single-cycle commands with no handshake: each write or ALU strobe takes effect at the next rising edge, and the block never stalls.

Top module: `mac_datapath`

## Requirements
- R1: On a clock edge with `x_we` or `y_we` high, `p_q` becomes bits [31:8] of the 32-bit value 2·X·Y, where X and Y are the new signed register contents. For example, 4000h·4000h gives 200000h and 4000h·C000h gives E00000h.
- R2: `p_q` changes only on edges where `x_we` or `y_we` is high. No input writes P directly.
- R3: The product of 8000h and 8000h stores 800000h (negative full scale), not a positive value.
- R4: With `pre_shift3` high during an operand write, the doubled product is arithmetically shifted right by 3 before bits [31:8] are kept. For example, 4000h·4000h gives 040000h.
- R5: The ALU operand is P after the shifter selected by `shift_sel`: 0 passes P unchanged, 1 shifts it arithmetically right by 1, 2 shifts it left by 1 and drops the top bit, 3 shifts it arithmetically right by 3.
- R6: The `alu_op` codes are 0 ADD (acc + operand), 1 SUB (acc − operand) and 2 LDP (acc = operand). They use the P value held before the edge, even when X or Y is written on the same edge.
- R7: When an arithmetic result overflows, `sat_en`=1 clamps the accumulator to 7FFFFFh or 800000h according to the direction of the overflow. With `sat_en`=0 the accumulator keeps the wrapped 24-bit result. `flag_ov` is set in both cases.
- R8: After an ALU operation, `flag_n` is bit 23 of the new accumulator and `flag_z` is set when the new accumulator is zero. For arithmetic operations, `flag_ov` reports signed overflow. `flag_c` is the unsigned carry out of bit 23 for additions and the unsigned borrow for subtractions.
- R9: `acc_we` loads `acc_din` into accumulator bits [23:8] and clears bits [7:0]. `acc_hi` always shows accumulator bits [23:8].
- R10: The codes 3 NEG (0 − acc), 4 ABS (NEG when acc is negative, otherwise acc + 0), 5 INC (acc + 1) and 6 DEC (acc − 1) follow the flag and saturation rules of R7 and R8.
- R11: The codes 7 ROR, 8 ROL, 9 SRA, 10 SRL and 11 SLA shift or rotate the accumulator by one bit, with the bit shifted out going to `flag_c`. Only SLA can overflow, when bits 23 and 22 differ, and it then obeys `sat_en`. ROR, ROL, SRA and SRL clear `flag_ov`.
- R12: With `alu_go` low, with `acc_we` high, or with codes 12 to 15, the ALU changes neither the accumulator nor the flags. `acc_we` takes priority over `alu_go`.
- R13: After reset, X, Y, P, the accumulator and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_we | input | 1 | Write strobe for X |
| x_din | input | 16 | New X value, signed Q15 |
| y_we | input | 1 | Write strobe for Y |
| y_din | input | 16 | New Y value, signed Q15 |
| pre_shift3 | input | 1 | Shift the product right by 3 before storing it in P |
| acc_we | input | 1 | Load the accumulator from acc_din |
| acc_din | input | 16 | Value loaded into accumulator bits [23:8] |
| alu_go | input | 1 | Perform the ALU operation at this edge |
| alu_op | input | 4 | ALU operation code |
| shift_sel | input | 2 | Operand shifter setting |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| p_q | output | 24 | Product register |
| acc_q | output | 24 | Accumulator |
| acc_hi | output | 16 | Accumulator bits [23:8] |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry or borrow flag |

## Verification
The assertions check rules that hold on every cycle. P stays stable without an operand write. An accumulator load places the word high and clears the low byte, and flags hold when no ALU operation runs. After each ALU operation, N and Z agree with the accumulator, and a saturating ADD that overflows ends at a full-scale value. The bench's scenarios are the only place where the arithmetic values themselves are shown: product truncation, the minus-one squared case, each shifter setting, the same-cycle use of the old P during a multiply-add, and the carry and overflow outcomes of negate, absolute value, increment, decrement and the single-bit shifts.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_LDP = 4'd2,
    OP_NEG = 4'd3,
    OP_ABS = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_ROR = 4'd7,
    OP_ROL = 4'd8,
    OP_SRA = 4'd9,
    OP_SRL = 4'd10,
    OP_SLA = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_R1   = 2'd1,
    SH_L1   = 2'd2,
    SH_R3   = 2'd3
  } shf_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          pre3,
  output logic [AW-1:0] p_next
);
  localparam int PW = 2 * DW;
  localparam int LO = PW - AW;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] dbl;
  logic signed [PW-1:0] scaled;

  assign prod   = $signed(x) * $signed(y);
  assign dbl    = prod <<< 1;
  assign scaled = pre3 ? (dbl >>> 3) : dbl;
  assign p_next = scaled[PW-1:LO];

  generate
    if (LO > 0) begin : g_lo
      logic unused_lo;
      assign unused_lo = ^scaled[LO-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_opshift.sv
module mac_opshift
  import mac_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] p_in,
  input  logic [1:0]    sel,
  output logic [AW-1:0] opnd
);
  always_comb begin
    unique case (shf_e'(sel))
      SH_R1:   opnd = {p_in[AW-1], p_in[AW-1:1]};
      SH_L1:   opnd = {p_in[AW-2:0], 1'b0};
      SH_R3:   opnd = {{3{p_in[AW-1]}}, p_in[AW-1:3]};
      default: opnd = p_in;
    endcase
  end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] opnd,
  input  logic [3:0]    op,
  input  logic          sat_en,
  output logic [AW-1:0] res,
  output flags_t        flg,
  output logic          upd
);
  localparam int M = AW - 1;
  localparam logic [AW-1:0] MAXV = {1'b0, {M{1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {M{1'b0}}};
  localparam logic [AW-1:0] ONE  = {{M{1'b0}}, 1'b1};

  logic [AW-1:0] a, b;
  logic          sub, arith;
  logic [AW:0]   sum;
  logic          ov_ar;
  logic [AW-1:0] sh_res;
  logic          sh_c, sh_ov;
  logic [AW-1:0] raw;
  logic          ov, cy, clamp_neg;

  always_comb begin
    a = acc; b = '0; sub = 1'b0; arith = 1'b1; upd = 1'b1;
    unique case (op)
      OP_ADD: b = opnd;
      OP_SUB: begin b = opnd; sub = 1'b1; end
      OP_LDP: begin a = '0; b = opnd; end
      OP_NEG: begin a = '0; b = acc; sub = 1'b1; end
      OP_ABS: if (acc[M]) begin a = '0; b = acc; sub = 1'b1; end
      OP_INC: b = ONE;
      OP_DEC: begin b = ONE; sub = 1'b1; end
      OP_ROR, OP_ROL, OP_SRA, OP_SRL, OP_SLA: arith = 1'b0;
      default: begin arith = 1'b0; upd = 1'b0; end
    endcase
  end

  assign sum   = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
  assign ov_ar = sub ? ((a[M] != b[M]) && (sum[M] != a[M]))
                     : ((a[M] == b[M]) && (sum[M] != a[M]));

  always_comb begin
    sh_res = acc; sh_c = 1'b0; sh_ov = 1'b0;
    unique case (op)
      OP_ROR:  begin sh_res = {acc[0], acc[M:1]};     sh_c = acc[0]; end
      OP_ROL:  begin sh_res = {acc[M-1:0], acc[M]};   sh_c = acc[M]; end
      OP_SRA:  begin sh_res = {acc[M], acc[M:1]};     sh_c = acc[0]; end
      OP_SRL:  begin sh_res = {1'b0, acc[M:1]};       sh_c = acc[0]; end
      OP_SLA:  begin sh_res = {acc[M-1:0], 1'b0};     sh_c = acc[M];
                     sh_ov = acc[M] ^ acc[M-1]; end
      default: ;
    endcase
  end

  always_comb begin
    if (arith) begin
      raw = sum[M:0]; ov = ov_ar; cy = sum[AW]; clamp_neg = a[M];
    end else begin
      raw = sh_res; ov = sh_ov; cy = sh_c; clamp_neg = acc[M];
    end
    res = (ov && sat_en) ? (clamp_neg ? MINV : MAXV) : raw;
    flg.n  = res[M];
    flg.z  = (res == '0);
    flg.ov = ov;
    flg.c  = cy;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_we,
  input  logic [DW-1:0] x_din,
  input  logic          y_we,
  input  logic [DW-1:0] y_din,
  input  logic          pre_shift3,
  input  logic          acc_we,
  input  logic [DW-1:0] acc_din,
  input  logic          alu_go,
  input  logic [3:0]    alu_op,
  input  logic [1:0]    shift_sel,
  input  logic          sat_en,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] acc_q,
  output logic [DW-1:0] acc_hi,
  output logic          flag_n,
  output logic          flag_ov,
  output logic          flag_z,
  output logic          flag_c
);
  localparam int PADW = AW - DW;

  logic [DW-1:0] x_r, y_r, x_nx, y_nx;
  logic [AW-1:0] p_nx, opnd, alu_res;
  flags_t        flg_r, alu_flg;
  logic          alu_upd;

  assign x_nx = x_we ? x_din : x_r;
  assign y_nx = y_we ? y_din : y_r;

  mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .x(x_nx), .y(y_nx), .pre3(pre_shift3), .p_next(p_nx)
  );

  mac_opshift #(.AW(AW)) u_shf (
    .p_in(p_q), .sel(shift_sel), .opnd(opnd)
  );

  mac_alu #(.AW(AW)) u_alu (
    .acc(acc_q), .opnd(opnd), .op(alu_op), .sat_en(sat_en),
    .res(alu_res), .flg(alu_flg), .upd(alu_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r   <= '0;
      y_r   <= '0;
      p_q   <= '0;
      acc_q <= '0;
      flg_r <= '0;
    end else begin
      x_r <= x_nx;
      y_r <= y_nx;
      if (x_we || y_we) p_q <= p_nx;
      if (acc_we) begin
        acc_q <= {acc_din, {PADW{1'b0}}};
      end else if (alu_go && alu_upd) begin
        acc_q <= alu_res;
        flg_r <= alu_flg;
      end
    end
  end

  assign acc_hi  = acc_q[AW-1:PADW];
  assign flag_n  = flg_r.n;
  assign flag_ov = flg_r.ov;
  assign flag_z  = flg_r.z;
  assign flag_c  = flg_r.c;
endmodule

// File: rtl/mac_datapath_chk.sv
module mac_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          x_we,
  input logic [DW-1:0] x_din,
  input logic          y_we,
  input logic [DW-1:0] y_din,
  input logic          pre_shift3,
  input logic          acc_we,
  input logic [DW-1:0] acc_din,
  input logic          alu_go,
  input logic [3:0]    alu_op,
  input logic          sat_en,
  input logic [AW-1:0] p_q,
  input logic [AW-1:0] acc_q,
  input logic [DW-1:0] acc_hi,
  input logic          flag_n,
  input logic          flag_ov,
  input logic          flag_z,
  input logic          flag_c
);
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};
  localparam logic [DW-1:0] NEG1 = {1'b1, {(DW-1){1'b0}}};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_we || y_we) |=> $stable(p_q));

  p_minsq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_we && y_we && x_din == NEG1 && y_din == NEG1 && !pre_shift3) |=> (p_q == MINV));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> (acc_hi == $past(acc_din)) && (acc_q[AW-DW-1:0] == '0));

  p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_go || acc_we) |=> $stable({flag_n, flag_ov, flag_z, flag_c}));

  p_nz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_go && !acc_we && alu_op < 4'd12) |=>
      (flag_n == acc_q[AW-1]) && (flag_z == (acc_q == '0)));

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_go && !acc_we && sat_en && alu_op == 4'd0) |=>
      (!flag_ov || acc_q == MAXV || acc_q == MINV));
endmodule

bind mac_datapath mac_datapath_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_mac_datapath.sv
`timescale 1ns/1ps
module tb_mac_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_we = 0, y_we = 0, pre_shift3 = 0, acc_we = 0, alu_go = 0, sat_en = 0;
  logic [15:0] x_din = 0, y_din = 0, acc_din = 0;
  logic [3:0]  alu_op = 0;
  logic [1:0]  shift_sel = 0;
  logic [23:0] p_q, acc_q;
  logic [15:0] acc_hi;
  logic flag_n, flag_ov, flag_z, flag_c;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur = "R13";

  // behavioural reference state
  logic [15:0] mx = 0, my = 0;
  logic [23:0] mp = 0, macc = 0;
  logic mn = 0, mov = 0, mz = 0, mc = 0;

  always #5 clk = ~clk;

  mac_datapath dut (
    .clk(clk), .rst_n(rst_n), .x_we(x_we), .x_din(x_din), .y_we(y_we), .y_din(y_din),
    .pre_shift3(pre_shift3), .acc_we(acc_we), .acc_din(acc_din), .alu_go(alu_go),
    .alu_op(alu_op), .shift_sel(shift_sel), .sat_en(sat_en), .p_q(p_q), .acc_q(acc_q),
    .acc_hi(acc_hi), .flag_n(flag_n), .flag_ov(flag_ov), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] shifted_p(logic [23:0] p, logic [1:0] s);
    int v = $signed(p);
    case (s)
      2'd1: v = v >>> 1;
      2'd2: v = v * 2;
      2'd3: v = v >>> 3;
      default: ;
    endcase
    return v[23:0];
  endfunction

  task automatic arith(int a, int b, bit sub);
    int r = sub ? a - b : a + b;
    int ua = a & 32'hFFFFFF;
    int ub = b & 32'hFFFFFF;
    bit ov = (r > 8388607) || (r < -8388608);
    mc = sub ? (ua < ub) : ((ua + ub) > 32'hFFFFFF);
    mov = ov;
    if (ov && sat_en) r = (r > 0) ? 8388607 : -8388608;
    macc = r[23:0];
  endtask

  task automatic model_edge();
    int a = $signed(macc);
    logic [15:0] nx = x_we ? x_din : mx;
    logic [15:0] ny = y_we ? y_din : my;
    if (acc_we) macc = {acc_din, 8'h00};
    else if (alu_go && alu_op < 4'd12) begin
      case (alu_op)
        4'd0: arith(a, $signed(shifted_p(mp, shift_sel)), 0);
        4'd1: arith(a, $signed(shifted_p(mp, shift_sel)), 1);
        4'd2: arith(0, $signed(shifted_p(mp, shift_sel)), 0);
        4'd3: arith(0, a, 1);
        4'd4: if (a < 0) arith(0, a, 1); else arith(a, 0, 0);
        4'd5: arith(a, 1, 0);
        4'd6: arith(a, 1, 1);
        4'd7: begin mc = macc[0]; mov = 0; macc = {macc[0], macc[23:1]}; end
        4'd8: begin mc = macc[23]; mov = 0; macc = {macc[22:0], macc[23]}; end
        4'd9: begin mc = macc[0]; mov = 0; macc = {macc[23], macc[23:1]}; end
        4'd10: begin mc = macc[0]; mov = 0; macc = {1'b0, macc[23:1]}; end
        default: begin
          mc = macc[23]; mov = macc[23] ^ macc[22];
          if (mov && sat_en) macc = macc[23] ? 24'h800000 : 24'h7FFFFF;
          else macc = {macc[22:0], 1'b0};
        end
      endcase
      mn = macc[23];
      mz = (macc == 0);
    end
    if (x_we || y_we) begin
      longint q = longint'($signed(nx)) * longint'($signed(ny)) * 2;
      if (q == 64'sd2147483648) q = -64'sd2147483648;
      if (pre_shift3) q = q >>> 3;
      q = q >>> 8;
      mp = q[23:0];
    end
    mx = nx; my = ny;
  endtask

  task automatic compare();
    chk(cur, "p_q", {8'h0, p_q}, {8'h0, mp});
    chk(cur, "acc", {acc_hi, acc_q[23:8], acc_q[7:0]}, {macc[23:8], macc[23:8], macc[7:0]});
    chk(cur, "flags", {28'h0, flag_n, flag_ov, flag_z, flag_c}, {28'h0, mn, mov, mz, mc});
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    x_we = 0; y_we = 0; acc_we = 0; alu_go = 0; pre_shift3 = 0;
  endtask

  task automatic wr_xy(logic [15:0] xv, logic [15:0] yv);
    x_we = 1; y_we = 1; x_din = xv; y_din = yv; step();
  endtask

  task automatic ld_acc(logic [15:0] v);
    acc_we = 1; acc_din = v; step();
  endtask

  task automatic do_op(logic [3:0] op, logic [1:0] sh);
    alu_go = 1; alu_op = op; shift_sel = sh; step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = "R13"; compare();
    chk("R13", "reset acc", {8'h0, acc_q}, 32'h0);

    cur = "R1";
    wr_xy(16'h4000, 16'hC000);
    chk("R1", "0.5*-0.5", {8'h0, p_q}, 32'h00E00000);
    wr_xy(16'h4000, 16'h4000);
    chk("R1", "0.5*0.5", {8'h0, p_q}, 32'h00200000);

    cur = "R2";
    ld_acc(16'h1111);
    alu_go = 1; alu_op = 4'd0; step();
    chk("R2", "P untouched", {8'h0, p_q}, 32'h00200000);
    x_we = 1; x_din = 16'h2000; step();
    chk("R2", "x only write", {8'h0, p_q}, 32'h00100000);
    y_we = 1; y_din = 16'h4000; step();
    chk("R2", "y only write", {8'h0, p_q}, 32'h00100000);

    cur = "R3";
    wr_xy(16'h8000, 16'h8000);
    chk("R3", "min*min", {8'h0, p_q}, 32'h00800000);

    cur = "R4";
    pre_shift3 = 1; wr_xy(16'h4000, 16'h4000);
    chk("R4", "pre-shift", {8'h0, p_q}, 32'h00040000);
    pre_shift3 = 1; wr_xy(16'h8000, 16'h8000);
    chk("R4", "pre-shift min", {8'h0, p_q}, 32'h00F00000);

    cur = "R9";
    ld_acc(16'h1234);
    chk("R9", "acc load", {8'h0, acc_q}, 32'h00123400);
    chk("R9", "acc_hi", {16'h0, acc_hi}, 32'h00001234);

    cur = "R5";
    wr_xy(16'h4000, 16'h4000);
    do_op(4'd2, 2'd0); chk("R5", "none", {8'h0, acc_q}, 32'h00200000);
    do_op(4'd2, 2'd1); chk("R5", "right1", {8'h0, acc_q}, 32'h00100000);
    do_op(4'd2, 2'd2); chk("R5", "left1", {8'h0, acc_q}, 32'h00400000);
    do_op(4'd2, 2'd3); chk("R5", "right3", {8'h0, acc_q}, 32'h00040000);

    cur = "R6";
    ld_acc(16'h1000);
    alu_go = 1; alu_op = 4'd0; shift_sel = 0;
    x_we = 1; y_we = 1; x_din = 16'h4000; y_din = 16'h2000; step();
    chk("R6", "mac old P", {8'h0, acc_q}, 32'h00300000);
    chk("R6", "new P", {8'h0, p_q}, 32'h00100000);
    do_op(4'd1, 2'd0);
    chk("R6", "sub", {8'h0, acc_q}, 32'h00200000);

    cur = "R7";
    wr_xy(16'h4000, 16'h4000);
    ld_acc(16'h7000); sat_en = 1; do_op(4'd0, 2'd0);
    chk("R7", "clamp", {8'h0, acc_q}, 32'h007FFFFF);
    chk("R7", "ov set", {31'h0, flag_ov}, 32'h1);
    ld_acc(16'h7000); sat_en = 0; do_op(4'd0, 2'd0);
    chk("R7", "wrap", {8'h0, acc_q}, 32'h00900000);

    cur = "R10";
    ld_acc(16'h8000); do_op(4'd3, 2'd0);
    chk("R10", "neg min wrap", {8'h0, acc_q}, 32'h00800000);
    ld_acc(16'h8000); sat_en = 1; do_op(4'd3, 2'd0); sat_en = 0;
    chk("R10", "neg min sat", {8'h0, acc_q}, 32'h007FFFFF);
    ld_acc(16'hFF00); do_op(4'd4, 2'd0);
    chk("R10", "abs", {8'h0, acc_q}, 32'h00010000);
    ld_acc(16'hFFFF); do_op(4'd5, 2'd0);
    chk("R10", "inc", {8'h0, acc_q}, 32'h00FFFF01);
    ld_acc(16'h0000); do_op(4'd6, 2'd0);
    chk("R10", "dec", {8'h0, acc_q}, 32'h00FFFFFF);
    chk("R10", "dec borrow", {31'h0, flag_c}, 32'h1);

    cur = "R11";
    ld_acc(16'h8001); do_op(4'd7, 2'd0);
    chk("R11", "ror", {8'h0, acc_q}, 32'h00400080);
    ld_acc(16'h8001); do_op(4'd8, 2'd0);
    chk("R11", "rol", {8'h0, acc_q}, 32'h00000201);
    ld_acc(16'h8001); do_op(4'd9, 2'd0);
    chk("R11", "sra", {8'h0, acc_q}, 32'h00C00080);
    ld_acc(16'h8001); do_op(4'd10, 2'd0);
    chk("R11", "srl", {8'h0, acc_q}, 32'h00400080);
    ld_acc(16'h8001); do_op(4'd11, 2'd0);
    chk("R11", "sla", {8'h0, acc_q}, 32'h00000200);
    chk("R11", "sla ov", {31'h0, flag_ov}, 32'h1);

    cur = "R12";
    ld_acc(16'h0500);
    alu_op = 4'd0; step();
    chk("R12", "no go", {8'h0, acc_q}, 32'h00050000);
    acc_we = 1; acc_din = 16'h0600; alu_go = 1; alu_op = 4'd3; step();
    chk("R12", "load wins", {8'h0, acc_q}, 32'h00060000);
    do_op(4'd13, 2'd0);
    chk("R12", "unused code", {8'h0, acc_q}, 32'h00060000);

    cur = "R8";
    for (int i = 0; i < 600; i++) begin
      x_we = $urandom_range(0, 3) == 0; y_we = $urandom_range(0, 3) == 0;
      x_din = 16'($urandom); y_din = 16'($urandom);
      pre_shift3 = $urandom_range(0, 3) == 0;
      acc_we = $urandom_range(0, 7) == 0; acc_din = 16'($urandom);
      alu_go = $urandom_range(0, 1) == 1; alu_op = 4'($urandom);
      shift_sel = 2'($urandom); sat_en = 1'($urandom);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule